// File: doc/BRIEF.md
# PSRAM Power-Up and Configuration Sequencer

This block sits between a memory controller and a pseudo-static RAM. After power is applied it keeps the memory's chip enable inactive (high) for a fixed self-initialisation window. It counts that window in clock cycles and then raises `ready`. Until `ready` rises, the memory holds its default settings and runs in plain asynchronous mode.

Once ready, a client can ask the block to load either of the memory's two configuration registers. One is the bus setup register and the other is the refresh setup register. The new value travels on the address lines, not the data bus. A dedicated address bit picks the target register, and the register-select pin stays high around a write pulse. The data bus is never driven.

The block keeps a shadow copy of both registers. It also breaks out the fields the transfer controllers need: burst enable, wait polarity, clock polarity and page enable. A shadow register changes only after the write pulse has ended and chip enable is high again.

Top module: `psram_cfg_seq`

## Requirements
- R1: From reset until `ready` is high, `mem_ce_n` is 1 and `mem_cre` is 0, whatever the request inputs do.
- R2: `ready` rises on the POR_US*CLK_MHZ-th rising edge after reset is released (30000 with defaults) and stays high until the next reset.
- R3: While a write is in progress, `mem_addr` holds `req_value` in bits CFG_W-1:0 and `req_sel` in bit SEL_BIT (0 = bus register, 1 = refresh register), with all other bits 0.
- R4: An accepted write runs three phases. First, SETUP_CYC cycles with `mem_cre`=1 and `mem_ce_n`=1. Then PULSE_CYC cycles with `mem_ce_n`=0 and `mem_we_n`=0. Then HOLD_CYC cycles with `mem_cre`=1 and `mem_ce_n`=`mem_we_n`=1. `mem_oe_n` is 1 at all times.
- R5: A request made while `ready` is 0 or `busy` is 1 raises `req_reject` in that cycle. It does not change the memory pins or either shadow register.
- R6: The target shadow register takes the new value, and `wr_done` pulses for one cycle, in the cycle after the last hold cycle. The shadow never changes earlier, and the other shadow register keeps its value.
- R7: Synchronous reset, also during a write, returns the pins to idle, clears `ready`, restarts the power-up count and loads the shadow defaults: 0x0510 for the bus register and 0x0010 for the refresh register.
- R8: `burst_en` is bus shadow bit 15, `wait_pol` is bus shadow bit 10, `clk_pol` is bus shadow bit 6 and `page_en` is refresh shadow bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register write request |
| req_sel | input | 1 | Target: 0 bus register, 1 refresh register |
| req_value | input | CFG_W | Value to load |
| req_accept | output | 1 | Request taken this cycle |
| req_reject | output | 1 | Request refused this cycle |
| ready | output | 1 | Power-up wait complete |
| busy | output | 1 | Register write in progress |
| wr_done | output | 1 | One-cycle pulse when the shadow is updated |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_cre | output | 1 | Memory register-select pin |
| mem_addr | output | ADDR_W | Memory address lines carrying the value |
| bus_cfg | output | CFG_W | Shadow of the bus register |
| ref_cfg | output | CFG_W | Shadow of the refresh register |
| burst_en | output | 1 | Burst mode enabled |
| wait_pol | output | 1 | Wait signal polarity |
| clk_pol | output | 1 | Clock edge polarity |
| page_en | output | 1 | Page mode enabled |

## Verification
A new request can arrive in the same cycle that a finishing write updates its shadow register. A request can also arrive on the very edge at which `ready` rises. The bench provokes the first collision by holding a request with a different value through the whole write, including its last hold cycle. It provokes the second by holding a request across the edge before `ready` goes high. In both cases the bench expects `req_reject` and unchanged pins. It also expects the shadow to end with the first value only, and the next request to be accepted only once the block is idle.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } wr_state_e;

    typedef enum logic {
        SEL_BUS = 1'b0,
        SEL_REF = 1'b1
    } cfg_sel_e;

    localparam int BUS_BURST_BIT   = 15;
    localparam int BUS_WAITPOL_BIT = 10;
    localparam int BUS_CLKPOL_BIT  = 6;
    localparam int REF_PAGE_BIT    = 7;

    typedef struct packed {
        logic burst_en;
        logic wait_pol;
        logic clk_pol;
        logic page_en;
    } cfg_flags_t;

    function automatic int por_cycles(input int us, input int mhz);
        return us * mhz;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/psram_por_timer.sv
module psram_por_timer #(
    parameter int POR_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CNT_W = $clog2(POR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt_q == LAST) begin
                ready <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        $past(ready) |-> ready)
        else $error("ready dropped without reset");

endmodule

// File: rtl/psram_cfg_wr_fsm.sv
module psram_cfg_wr_fsm
    import psram_cfg_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int CFG_W     = 16,
    parameter int SEL_BIT   = 19,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready,
    input  logic              req_valid,
    input  logic              req_sel,
    input  logic [CFG_W-1:0]  req_value,
    output logic              req_accept,
    output logic              req_reject,
    output logic              busy,
    output logic              wr_done,
    output logic              upd_en,
    output logic              upd_sel,
    output logic [CFG_W-1:0]  upd_value,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_cre,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int MAXC = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int PH_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [PH_W-1:0] SETUP_LD = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0] PULSE_LD = PH_W'(PULSE_CYC - 1);
    localparam logic [PH_W-1:0] HOLD_LD  = PH_W'(HOLD_CYC - 1);

    wr_state_e        state_q;
    logic [PH_W-1:0]  ph_cnt_q;
    logic             sel_q;
    logic [CFG_W-1:0] val_q;
    logic             phase_end;

    function automatic logic [ADDR_W-1:0] pack_addr(input logic s, input logic [CFG_W-1:0] v);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[CFG_W-1:0] = v;
        a[SEL_BIT] = s;
        return a;
    endfunction

    assign busy       = (state_q != ST_IDLE);
    assign req_accept = req_valid && ready && !busy;
    assign req_reject = req_valid && !req_accept;
    assign phase_end  = (ph_cnt_q == '0);
    assign upd_en     = (state_q == ST_HOLD) && phase_end;
    assign upd_sel    = sel_q;
    assign upd_value  = val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ph_cnt_q <= '0;
            sel_q    <= 1'b0;
            val_q    <= '0;
            wr_done  <= 1'b0;
        end else begin
            wr_done <= upd_en;
            unique case (state_q)
                ST_IDLE: if (req_accept) begin
                    state_q  <= ST_SETUP;
                    ph_cnt_q <= SETUP_LD;
                    sel_q    <= req_sel;
                    val_q    <= req_value;
                end
                ST_SETUP: if (phase_end) begin
                    state_q  <= ST_PULSE;
                    ph_cnt_q <= PULSE_LD;
                end else begin
                    ph_cnt_q <= ph_cnt_q - 1'b1;
                end
                ST_PULSE: if (phase_end) begin
                    state_q  <= ST_HOLD;
                    ph_cnt_q <= HOLD_LD;
                end else begin
                    ph_cnt_q <= ph_cnt_q - 1'b1;
                end
                ST_HOLD: if (phase_end) begin
                    state_q <= ST_IDLE;
                end else begin
                    ph_cnt_q <= ph_cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_ce_n = (state_q != ST_PULSE);
        mem_we_n = (state_q != ST_PULSE);
        mem_oe_n = 1'b1;
        mem_cre  = busy;
        mem_addr = busy ? pack_addr(sel_q, val_q) : '0;
    end

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr))
        else $error("address moved during register write");

    p_busy_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> ready)
        else $error("write started before power-up completed");

endmodule

// File: rtl/psram_cfg_shadow.sv
module psram_cfg_shadow
    import psram_cfg_pkg::*;
#(
    parameter int              CFG_W       = 16,
    parameter logic [CFG_W-1:0] BUS_DEFAULT = 16'h0510,
    parameter logic [CFG_W-1:0] REF_DEFAULT = 16'h0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic             upd_sel,
    input  logic [CFG_W-1:0] upd_value,
    output logic [CFG_W-1:0] bus_cfg,
    output logic [CFG_W-1:0] ref_cfg,
    output cfg_flags_t       flags
);
    localparam int NREG = 2;
    logic [CFG_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [CFG_W-1:0] DEF = (g == int'(SEL_BUS)) ? BUS_DEFAULT : REF_DEFAULT;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= DEF;
            end else if (upd_en && (int'(upd_sel) == g)) begin
                regs_q[g] <= upd_value;
            end
        end
    end

    assign bus_cfg = regs_q[int'(SEL_BUS)];
    assign ref_cfg = regs_q[int'(SEL_REF)];

    always_comb begin
        flags.burst_en = bus_cfg[BUS_BURST_BIT];
        flags.wait_pol = bus_cfg[BUS_WAITPOL_BIT];
        flags.clk_pol  = bus_cfg[BUS_CLKPOL_BIT];
        flags.page_en  = ref_cfg[REF_PAGE_BIT];
    end

    p_other_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_sel) |=> $stable(bus_cfg))
        else $error("bus shadow touched by refresh write");

endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
    import psram_cfg_pkg::*;
#(
    parameter int               CLK_MHZ     = 200,
    parameter int               POR_US      = 150,
    parameter int               ADDR_W      = 21,
    parameter int               CFG_W       = 16,
    parameter int               SEL_BIT     = 19,
    parameter int               SETUP_CYC   = 2,
    parameter int               PULSE_CYC   = 4,
    parameter int               HOLD_CYC    = 2,
    parameter logic [CFG_W-1:0] BUS_DEFAULT = 16'h0510,
    parameter logic [CFG_W-1:0] REF_DEFAULT = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_sel,
    input  logic [CFG_W-1:0]  req_value,
    output logic              req_accept,
    output logic              req_reject,
    output logic              ready,
    output logic              busy,
    output logic              wr_done,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_cre,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CFG_W-1:0]  bus_cfg,
    output logic [CFG_W-1:0]  ref_cfg,
    output logic              burst_en,
    output logic              wait_pol,
    output logic              clk_pol,
    output logic              page_en
);
    localparam int POR_CYCLES = por_cycles(POR_US, CLK_MHZ);

    logic             upd_en;
    logic             upd_sel;
    logic [CFG_W-1:0] upd_value;
    cfg_flags_t       flags;

    psram_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst   (rst),
        .ready (ready)
    );

    psram_cfg_wr_fsm #(
        .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SEL_BIT(SEL_BIT),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ready      (ready),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .req_value  (req_value),
        .req_accept (req_accept),
        .req_reject (req_reject),
        .busy       (busy),
        .wr_done    (wr_done),
        .upd_en     (upd_en),
        .upd_sel    (upd_sel),
        .upd_value  (upd_value),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_cre    (mem_cre),
        .mem_addr   (mem_addr)
    );

    psram_cfg_shadow #(
        .CFG_W(CFG_W), .BUS_DEFAULT(BUS_DEFAULT), .REF_DEFAULT(REF_DEFAULT)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .upd_sel   (upd_sel),
        .upd_value (upd_value),
        .bus_cfg   (bus_cfg),
        .ref_cfg   (ref_cfg),
        .flags     (flags)
    );

    assign burst_en = flags.burst_en;
    assign wait_pol = flags.wait_pol;
    assign clk_pol  = flags.clk_pol;
    assign page_en  = flags.page_en;

    p_ce_high_por_r1: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (mem_ce_n && !mem_cre))
        else $error("memory touched during power-up wait");

    p_pulse_pins_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (!mem_we_n && mem_oe_n && mem_cre))
        else $error("wrong pin levels during write pulse");

    p_shadow_after_ce_r6: assert property (@(posedge clk) disable iff (rst)
        ((bus_cfg != $past(bus_cfg)) || (ref_cfg != $past(ref_cfg)))
            |-> (mem_ce_n && $past(mem_ce_n) && $past(mem_cre)))
        else $error("shadow changed before chip enable returned high");

endmodule

// File: tb/test_psram_cfg_seq.sv
module test_psram_cfg_seq;
    localparam int S = 2, P = 4, H = 2;
    localparam int POR = 150 * 200;
    localparam int LEN = S + P + H;
    localparam int NVEC = 6;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'h8510}, {1'b1, 16'h0090}, {1'b0, 16'h0440},
        {1'b1, 16'h0000}, {1'b0, 16'hFFFF}, {1'b0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_sel = 1'b0;
    logic [15:0] req_value = '0;
    logic        req_accept, req_reject, ready, busy, wr_done;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_cre;
    logic [20:0] mem_addr;
    logic [15:0] bus_cfg, ref_cfg;
    logic        burst_en, wait_pol, clk_pol, page_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_bus = 16'h0510;
    logic [15:0] m_ref = 16'h0010;

    always #2.5 clk = ~clk;

    psram_cfg_seq #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) i_psram_cfg_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_value(req_value), .req_accept(req_accept), .req_reject(req_reject),
        .ready(ready), .busy(busy), .wr_done(wr_done), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_cre(mem_cre),
        .mem_addr(mem_addr), .bus_cfg(bus_cfg), .ref_cfg(ref_cfg),
        .burst_en(burst_en), .wait_pol(wait_pol), .clk_pol(clk_pol), .page_en(page_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_shadow(input string req);
        check(bus_cfg == m_bus, req, 32'(bus_cfg), 32'(m_bus));
        check(ref_cfg == m_ref, req, 32'(ref_cfg), 32'(m_ref));
        check({burst_en, wait_pol, clk_pol, page_en} ==
              {m_bus[15], m_bus[10], m_bus[6], m_ref[7]}, "R8",
              32'({burst_en, wait_pol, clk_pol, page_en}),
              32'({m_bus[15], m_bus[10], m_bus[6], m_ref[7]}));
    endtask

    // Runs one write; if poke is set, a conflicting request is held for the whole write.
    task automatic do_write(input logic sel, input logic [15:0] val, input bit poke);
        logic [20:0] exp_addr;
        bit pins_ok = 1;
        bit early_ok = 1;
        bit rej_ok = 1;
        exp_addr = '0;
        exp_addr[15:0] = val;
        exp_addr[19] = sel;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_value = val;
        #1;
        check(req_accept && !req_reject, "R5 accept when idle", 32'(req_accept), 32'd1);
        @(posedge clk);
        for (int j = 0; j <= LEN; j++) begin
            @(negedge clk);
            if (j < LEN && poke) begin
                req_valid = 1'b1; req_sel = ~sel; req_value = ~val;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (j < LEN) begin
                if (mem_ce_n != !(j >= S && j < S + P)) pins_ok = 0;
                if (mem_we_n != mem_ce_n || !mem_oe_n || !mem_cre || !busy) pins_ok = 0;
                if (mem_addr != exp_addr) pins_ok = 0;
                if (bus_cfg != m_bus || ref_cfg != m_ref || wr_done) early_ok = 0;
                if (poke && (!req_reject || req_accept)) rej_ok = 0;
            end
        end
        check(pins_ok, "R4 R3 phase pins/address", 32'(mem_addr), 32'(exp_addr));
        check(early_ok, "R6 no early shadow change", 32'(bus_cfg), 32'(m_bus));
        if (poke) check(rej_ok, "R5 reject while busy", 32'(req_reject), 32'd1);
        if (sel) m_ref = val; else m_bus = val;
        check(wr_done && !busy && mem_ce_n && !mem_cre, "R6 done pulse at idle",
              32'({wr_done, busy, mem_ce_n, mem_cre}), 32'b1010);
        check_shadow("R6 shadow updated");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        #1;
        check(!ready && mem_ce_n && !mem_cre && mem_oe_n, "R7 reset pins",
              32'({ready, mem_ce_n, mem_cre, mem_oe_n}), 32'b0101);
        check_shadow("R7 reset defaults");
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b1; req_sel = 1'b0; req_value = 16'hABCD;
        #1;
        check(req_reject && !req_accept, "R5 reject before ready", 32'(req_reject), 32'd1);
        repeat (POR - 1) @(posedge clk);
        @(negedge clk); #1;
        check(!ready && mem_ce_n && !mem_cre, "R1 R2 still waiting",
              32'({ready, mem_ce_n, mem_cre}), 32'b010);
        check(req_reject, "R5 reject on ready edge", 32'(req_reject), 32'd1);
        check_shadow("R5 shadow untouched before ready");
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(ready && !busy && mem_ce_n, "R2 ready after wait",
              32'({ready, busy, mem_ce_n}), 32'b101);

        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][16], VEC[v][15:0], v == 2);
        end

        do_write(1'b1, 16'h0080, 1'b0);
        check(page_en, "R8 page bit", 32'(page_en), 32'd1);

        // Reset during a write.
        @(negedge clk);
        req_valid = 1'b1; req_sel = 1'b1; req_value = 16'h1234;
        repeat (S + 1) @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk); #1;
        m_bus = 16'h0510; m_ref = 16'h0010;
        check(!busy && !ready && mem_ce_n && !mem_cre && mem_addr == '0, "R7 abort write",
              32'({busy, ready, mem_ce_n, mem_cre}), 32'b0010);
        check_shadow("R7 defaults after abort");
        @(negedge clk);
        rst = 1'b0;
        repeat (POR - 1) @(posedge clk);
        @(negedge clk); #1;
        check(!ready, "R2 restart count", 32'(ready), 32'd0);
        @(negedge clk); #1;
        check(ready, "R2 ready again", 32'(ready), 32'd1);
        do_write(1'b0, 16'h8040, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(190000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule